// File: doc/BRIEF.md
# Address Translation Fault Sequencer

This block handles one address translation at a time and reports how it ends. A requester presents an effective address together with an instruction/data flag, a read/write flag and the fields of the selected segment descriptor. It also presents two flags from an external block-translation array, a match flag and a violation flag, with the block's physical page number. The block holds the request in its own registers. It then settles the access in one of four ways: a completed translation with a physical address, a hand-off to the direct-store path, a storage exception, or a page-table search.

Translated pages are cached in two small TLBs, one for instruction fetches and one for data accesses. On a miss, the block issues a walk request that carries the virtual page number, which is the segment's virtual segment ID joined to the page index. It then waits for the walker's answer. A found entry is written into the TLB for that access type and the lookup is replayed, so the completed translation always comes from a TLB hit. Each failure becomes a one-cycle exception. The exception carries a one-hot 32-bit status word and a flag that tells the instruction-storage kind from the data-storage kind.

Top module: `mmu_xlate_seq`

## Requirements
- R1: After reset, done, exc_valid, dstore and walk_req_valid are low, exc_status is zero, and both TLBs are empty, so the first page access of either kind issues a walk.
- R2: A captured request with bat_hit=1 never issues a walk. If bat_viol=0, it completes with pa = {bat_ppn, ea[11:0]}. If bat_viol=1, it raises a protection exception (status bit 4).
- R3: An instruction fetch with seg_nx=1 and no block match raises an instruction-storage exception (exc_is_data=0) with status bit 3 set and issues no walk. A data access ignores seg_nx.
- R4: A request with seg_t=1 and no block match pulses dstore for one cycle. It issues no walk and raises neither done nor exc_valid.
- R5: On a TLB miss, walk_req_valid rises and walk_vpn = {seg_vsid, ea[27:12]}. Both stay stable until a cycle with walk_rsp_valid=1.
- R6: A walk answer with walk_rsp_found=1 allocates the entry. The replayed lookup hits, and done is raised with pa = {walk_rsp_ppn, ea[11:0]}.
- R7: A walk answer with walk_rsp_found=0 raises a page-fault exception with status bit 1 set. exc_is_data is 0 for a fetch and 1 for a data access.
- R8: Page protection uses the key bit seg_key and the entry's 2-bit pp field. With key 0, every code grants reads and writes, except pp=11, which is read-only. With key 1, pp=00 grants nothing, pp=01 and pp=11 are read-only, and pp=10 grants reads and writes. Fetches count as reads. A denied access raises an exception with status bit 4.
- R9: Instruction and data translations are cached separately. An entry filled by a data access does not serve a fetch of the same page.
- R10: Each TLB has 4 entries and replaces them round-robin from entry 0. After five fills of distinct pages since reset, the fifth page hits and the first page misses.
- R11: A request that hits in the TLB, or is settled by a block match, the no-execute check or the direct-store check, is answered on the second rising edge after req_valid is first sampled. Every answer (done, exc_valid, dstore) is a single-cycle pulse.
- R12: Status bit k is exc_status[31-k]. While exc_valid=1 exactly one bit of exc_status is set. While exc_valid=0 exc_status is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until its answer |
| req_ea | input | 32 | Effective address |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = store (data accesses only) |
| seg_t | input | 1 | Segment is direct-store |
| seg_nx | input | 1 | Segment forbids instruction fetch |
| seg_key | input | 1 | Protection key selected for this access |
| seg_vsid | input | 24 | Virtual segment ID |
| bat_hit | input | 1 | Block-translation array matched |
| bat_viol | input | 1 | Block match denies this access |
| bat_ppn | input | 20 | Physical page number from the block match |
| walk_req_valid | output | 1 | Page-table search requested |
| walk_vpn | output | 40 | Virtual page number to search |
| walk_rsp_valid | input | 1 | Search answer present |
| walk_rsp_found | input | 1 | Search found a valid entry |
| walk_rsp_ppn | input | 20 | Physical page number of the found entry |
| walk_rsp_pp | input | 2 | Page protection code of the found entry |
| done | output | 1 | Translation completed (one cycle) |
| pa | output | 32 | Physical address, valid with done |
| dstore | output | 1 | Handed to the direct-store path (one cycle) |
| exc_valid | output | 1 | Storage exception (one cycle) |
| exc_is_data | output | 1 | 0 = instruction-storage, 1 = data-storage |
| exc_status | output | 32 | One-hot exception status word |

## Verification
The hardest state to reach from the ports is a full TLB that has wrapped its replacement pointer. Only walks that find their entry advance the pointer, and the block hides it. The bench resets the block and runs five data walks to distinct pages. It then probes the newest and the oldest page and counts the walks each probe causes. A second hard case is a protection fault on the replayed lookup rather than on a first-cycle hit. Each protection scenario therefore uses a fresh page, so the denial comes after a walk and a refill.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WALK,
        ST_RETRY
    } xl_state_e;

    typedef enum logic [1:0] {
        FK_PAGE,
        FK_PROT,
        FK_NOEXEC
    } fault_kind_e;

    typedef enum logic [2:0] {
        OC_NONE,
        OC_DONE_BLK,
        OC_DONE_TLB,
        OC_FAULT,
        OC_DSTORE,
        OC_GO_WALK,
        OC_GO_RETRY
    } outcome_e;

    localparam int unsigned SB_PAGE   = 1;
    localparam int unsigned SB_NOEXEC = 3;
    localparam int unsigned SB_PROT   = 4;

    function automatic logic prot_grant(input logic key, input logic [1:0] pp,
                                        input logic wr);
        logic ok;
        if (!key) begin
            ok = wr ? (pp != 2'b11) : 1'b1;
        end else begin
            case (pp)
                2'b00:   ok = 1'b0;
                2'b10:   ok = 1'b1;
                default: ok = !wr;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned VPN_W   = 40,
    parameter int unsigned PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [1:0]       lk_pp,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_pp
);

    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0][1:0]       pp;
        logic [PTR_W-1:0]              ptr;
    } tlb_t;

    tlb_t t_d, t_q;

    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_pp  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!lk_hit && t_q.valid[i] && (t_q.vpn[i] == lk_vpn)) begin
                lk_hit = 1'b1;
                lk_ppn = t_q.ppn[i];
                lk_pp  = t_q.pp[i];
            end
        end
    end

    always_comb begin
        t_d = t_q;
        if (wr_en) begin
            t_d.valid[t_q.ptr] = 1'b1;
            t_d.vpn[t_q.ptr]   = wr_vpn;
            t_d.ppn[t_q.ptr]   = wr_ppn;
            t_d.pp[t_q.ptr]    = wr_pp;
            if (t_q.ptr == PTR_W'(ENTRIES - 1)) begin
                t_d.ptr = '0;
            end else begin
                t_d.ptr = t_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/mmu_fault_encode.sv
module mmu_fault_encode
    import mmu_xlate_pkg::*;
#(
    parameter int unsigned STAT_W = 32
) (
    input  fault_kind_e       kind,
    input  logic              is_instr,
    output logic [STAT_W-1:0] status,
    output logic              is_data
);

    always_comb begin
        status  = '0;
        is_data = !is_instr;
        case (kind)
            FK_PAGE:   status[STAT_W-1-SB_PAGE] = 1'b1;
            FK_PROT:   status[STAT_W-1-SB_PROT] = 1'b1;
            FK_NOEXEC: begin
                status[STAT_W-1-SB_NOEXEC] = 1'b1;
                is_data = 1'b0;
            end
            default:   status[STAT_W-1-SB_PAGE] = 1'b1;
        endcase
    end

endmodule

// File: rtl/mmu_xlate_seq.sv
module mmu_xlate_seq
    import mmu_xlate_pkg::*;
#(
    parameter int unsigned EA_W        = 32,
    parameter int unsigned PO_W        = 12,
    parameter int unsigned SEG_SEL_W   = 4,
    parameter int unsigned VSID_W      = 24,
    parameter int unsigned STAT_W      = 32,
    parameter int unsigned TLB_ENTRIES = 4,
    localparam int unsigned PPN_W      = EA_W - PO_W,
    localparam int unsigned PIDX_W     = EA_W - SEG_SEL_W - PO_W,
    localparam int unsigned VPN_W      = VSID_W + PIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_instr,
    input  logic              req_write,
    input  logic              seg_t,
    input  logic              seg_nx,
    input  logic              seg_key,
    input  logic [VSID_W-1:0] seg_vsid,
    input  logic              bat_hit,
    input  logic              bat_viol,
    input  logic [PPN_W-1:0]  bat_ppn,
    output logic              walk_req_valid,
    output logic [VPN_W-1:0]  walk_vpn,
    input  logic              walk_rsp_valid,
    input  logic              walk_rsp_found,
    input  logic [PPN_W-1:0]  walk_rsp_ppn,
    input  logic [1:0]        walk_rsp_pp,
    output logic              done,
    output logic [EA_W-1:0]   pa,
    output logic              dstore,
    output logic              exc_valid,
    output logic              exc_is_data,
    output logic [STAT_W-1:0] exc_status
);

    typedef struct packed {
        xl_state_e         state;
        logic [EA_W-1:0]   ea;
        logic              instr;
        logic              write;
        logic              seg_t;
        logic              nx;
        logic              key;
        logic [VSID_W-1:0] vsid;
        logic              blk_hit;
        logic              blk_viol;
        logic [PPN_W-1:0]  blk_ppn;
        logic              done;
        logic [EA_W-1:0]   pa;
        logic              dstore;
        logic              exc;
        logic              exc_data;
        logic [STAT_W-1:0] exc_stat;
    } seq_t;

    seq_t r_d, r_q;

    logic [VPN_W-1:0]  cur_vpn;
    logic [1:0]        tlb_hit;
    logic [PPN_W-1:0]  tlb_ppn [2];
    logic [1:0]        tlb_pp  [2];
    logic              sel_hit;
    logic [PPN_W-1:0]  sel_ppn;
    logic [1:0]        sel_pp;
    logic              tlb_we;
    logic              prot_ok;
    outcome_e          outcome;
    fault_kind_e       fault_kind;
    logic [STAT_W-1:0] enc_status;
    logic              enc_is_data;
    logic              in_retry;
    logic              nx_fetch;

    assign cur_vpn = {r_q.vsid, r_q.ea[EA_W-SEG_SEL_W-1:PO_W]};

    // Index 0 serves data accesses, index 1 serves instruction fetches.
    for (genvar g = 0; g < 2; g++) begin : g_tlb
        mmu_tlb #(
            .ENTRIES (TLB_ENTRIES),
            .VPN_W   (VPN_W),
            .PPN_W   (PPN_W)
        ) u_tlb (
            .clk    (clk),
            .rst_n  (rst_n),
            .lk_vpn (cur_vpn),
            .lk_hit (tlb_hit[g]),
            .lk_ppn (tlb_ppn[g]),
            .lk_pp  (tlb_pp[g]),
            .wr_en  (tlb_we && (r_q.instr == (g == 1))),
            .wr_vpn (cur_vpn),
            .wr_ppn (walk_rsp_ppn),
            .wr_pp  (walk_rsp_pp)
        );
    end

    assign sel_hit = r_q.instr ? tlb_hit[1] : tlb_hit[0];
    assign sel_ppn = r_q.instr ? tlb_ppn[1] : tlb_ppn[0];
    assign sel_pp  = r_q.instr ? tlb_pp[1]  : tlb_pp[0];
    assign prot_ok = prot_grant(r_q.key, sel_pp, r_q.write && !r_q.instr);
    assign tlb_we  = (r_q.state == ST_WALK) && walk_rsp_valid && walk_rsp_found;

    mmu_fault_encode #(
        .STAT_W (STAT_W)
    ) u_enc (
        .kind     (fault_kind),
        .is_instr (r_q.instr),
        .status   (enc_status),
        .is_data  (enc_is_data)
    );

    // Decide how the current state settles the access.
    always_comb begin
        outcome    = OC_NONE;
        fault_kind = FK_PAGE;
        case (r_q.state)
            ST_CHECK: begin
                if (r_q.blk_hit) begin
                    if (r_q.blk_viol) begin
                        outcome    = OC_FAULT;
                        fault_kind = FK_PROT;
                    end else begin
                        outcome = OC_DONE_BLK;
                    end
                end else if (r_q.instr && r_q.nx) begin
                    outcome    = OC_FAULT;
                    fault_kind = FK_NOEXEC;
                end else if (r_q.seg_t) begin
                    outcome = OC_DSTORE;
                end else if (sel_hit) begin
                    if (prot_ok) begin
                        outcome = OC_DONE_TLB;
                    end else begin
                        outcome    = OC_FAULT;
                        fault_kind = FK_PROT;
                    end
                end else begin
                    outcome = OC_GO_WALK;
                end
            end
            ST_WALK: begin
                if (walk_rsp_valid) begin
                    if (walk_rsp_found) begin
                        outcome = OC_GO_RETRY;
                    end else begin
                        outcome    = OC_FAULT;
                        fault_kind = FK_PAGE;
                    end
                end
            end
            ST_RETRY: begin
                if (sel_hit && prot_ok) begin
                    outcome = OC_DONE_TLB;
                end else if (sel_hit) begin
                    outcome    = OC_FAULT;
                    fault_kind = FK_PROT;
                end else begin
                    outcome    = OC_FAULT;
                    fault_kind = FK_PAGE;
                end
            end
            default: outcome = OC_NONE;
        endcase
    end

    // Next-state computation.
    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.dstore   = 1'b0;
        r_d.exc      = 1'b0;
        r_d.exc_data = 1'b0;
        r_d.exc_stat = '0;
        r_d.pa       = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state    = ST_CHECK;
                    r_d.ea       = req_ea;
                    r_d.instr    = req_instr;
                    r_d.write    = req_write;
                    r_d.seg_t    = seg_t;
                    r_d.nx       = seg_nx;
                    r_d.key      = seg_key;
                    r_d.vsid     = seg_vsid;
                    r_d.blk_hit  = bat_hit;
                    r_d.blk_viol = bat_viol;
                    r_d.blk_ppn  = bat_ppn;
                end
            end
            default: begin
                case (outcome)
                    OC_DONE_BLK: begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.pa    = {r_q.blk_ppn, r_q.ea[PO_W-1:0]};
                    end
                    OC_DONE_TLB: begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.pa    = {sel_ppn, r_q.ea[PO_W-1:0]};
                    end
                    OC_FAULT: begin
                        r_d.state    = ST_IDLE;
                        r_d.exc      = 1'b1;
                        r_d.exc_data = enc_is_data;
                        r_d.exc_stat = enc_status;
                    end
                    OC_DSTORE: begin
                        r_d.state  = ST_IDLE;
                        r_d.dstore = 1'b1;
                    end
                    OC_GO_WALK:  r_d.state = ST_WALK;
                    OC_GO_RETRY: r_d.state = ST_RETRY;
                    default:     r_d.state = r_q.state;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign walk_req_valid = (r_q.state == ST_WALK);
    assign walk_vpn       = cur_vpn;
    assign done           = r_q.done;
    assign pa             = r_q.pa;
    assign dstore         = r_q.dstore;
    assign exc_valid      = r_q.exc;
    assign exc_is_data    = r_q.exc_data;
    assign exc_status     = r_q.exc_stat;
    assign in_retry       = (r_q.state == ST_RETRY);
    assign nx_fetch       = r_q.instr && r_q.nx;

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
    parameter int unsigned STAT_W = 32,
    parameter int unsigned VPN_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              dstore,
    input logic              exc_valid,
    input logic              exc_is_data,
    input logic [STAT_W-1:0] exc_status,
    input logic              walk_req_valid,
    input logic              walk_rsp_valid,
    input logic [VPN_W-1:0]  walk_vpn,
    input logic              in_retry,
    input logic              retry_hit,
    input logic              nx_fetch,
    input logic              cap_direct,
    input logic              cap_blk
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid); // R11
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, exc_valid, dstore})); // R11
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($countones(exc_status) == 1)); // R12
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_status == '0)); // R12
    AST_NOEXEC_ISI: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_status[STAT_W-4]) |-> !exc_is_data); // R3
    AST_NOEXEC_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !nx_fetch); // R3
    AST_DIRECT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !cap_direct); // R4
    AST_BLOCK_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !cap_blk); // R2
    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_vpn))); // R5
    AST_RETRY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        in_retry |-> retry_hit); // R6

endmodule

bind mmu_xlate_seq mmu_xlate_chk #(
    .STAT_W (STAT_W),
    .VPN_W  (VPN_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .done           (done),
    .dstore         (dstore),
    .exc_valid      (exc_valid),
    .exc_is_data    (exc_is_data),
    .exc_status     (exc_status),
    .walk_req_valid (walk_req_valid),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_vpn       (walk_vpn),
    .in_retry       (in_retry),
    .retry_hit      (sel_hit),
    .nx_fetch       (nx_fetch),
    .cap_direct     (r_q.seg_t),
    .cap_blk        (r_q.blk_hit)
);

// File: tb/test_mmu_xlate_seq.sv
module test_mmu_xlate_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_instr = 1'b0;
    logic        req_write = 1'b0;
    logic        seg_t = 1'b0;
    logic        seg_nx = 1'b0;
    logic        seg_key = 1'b0;
    logic [23:0] seg_vsid = '0;
    logic        bat_hit = 1'b0;
    logic        bat_viol = 1'b0;
    logic [19:0] bat_ppn = '0;
    logic        walk_req_valid;
    logic [39:0] walk_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_found = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic [1:0]  walk_rsp_pp = '0;
    logic        done;
    logic [31:0] pa;
    logic        dstore;
    logic        exc_valid;
    logic        exc_is_data;
    logic [31:0] exc_status;

    always #5 clk = ~clk;

    mmu_xlate_seq i_mmu_xlate_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ea         (req_ea),
        .req_instr      (req_instr),
        .req_write      (req_write),
        .seg_t          (seg_t),
        .seg_nx         (seg_nx),
        .seg_key        (seg_key),
        .seg_vsid       (seg_vsid),
        .bat_hit        (bat_hit),
        .bat_viol       (bat_viol),
        .bat_ppn        (bat_ppn),
        .walk_req_valid (walk_req_valid),
        .walk_vpn       (walk_vpn),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_found (walk_rsp_found),
        .walk_rsp_ppn   (walk_rsp_ppn),
        .walk_rsp_pp    (walk_rsp_pp),
        .done           (done),
        .pa             (pa),
        .dstore         (dstore),
        .exc_valid      (exc_valid),
        .exc_is_data    (exc_is_data),
        .exc_status     (exc_status)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Result of the last access: 0 none, 1 done, 2 exception, 3 direct-store
    int          res_kind;
    int          res_cycles;
    int          res_walks;
    logic [39:0] res_vpn;
    logic [31:0] res_pa;
    logic [31:0] res_stat;
    logic        res_data;

    // Walker answer used by the next access
    logic        w_found;
    logic [19:0] w_ppn;
    logic [1:0]  w_pp;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        walk_rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic access(input logic [31:0] ea, input logic instr, input logic wr,
                          input logic t, input logic nx, input logic key,
                          input logic [23:0] vsid, input logic bh, input logic bv,
                          input logic [19:0] bp);
        bit seen = 0;
        int wait_ct = 0;
        req_ea = ea; req_instr = instr; req_write = wr; seg_t = t; seg_nx = nx;
        seg_key = key; seg_vsid = vsid; bat_hit = bh; bat_viol = bv; bat_ppn = bp;
        req_valid = 1'b1;
        res_kind = 0; res_cycles = 0; res_walks = 0; res_vpn = '0;
        res_pa = '0; res_stat = '0; res_data = 1'b0;
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            if (done || exc_valid || dstore) begin
                res_kind   = done ? 1 : (exc_valid ? 2 : 3);
                res_cycles = n;
                res_pa     = pa;
                res_stat   = exc_status;
                res_data   = exc_is_data;
                break;
            end
            if (walk_rsp_valid) begin
                walk_rsp_valid = 1'b0;
            end else if (walk_req_valid) begin
                if (!seen) begin
                    seen = 1;
                    res_walks++;
                    res_vpn = walk_vpn;
                end
                wait_ct++;
                if (wait_ct == 3) begin
                    walk_rsp_valid = 1'b1;
                    walk_rsp_found = w_found;
                    walk_rsp_ppn   = w_ppn;
                    walk_rsp_pp    = w_pp;
                end
            end
        end
        req_valid = 1'b0;
        walk_rsp_valid = 1'b0;
        @(negedge clk);
        if (res_kind == 0) begin
            chk(0, "R11", "access answered", 0, 1);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(!done && !exc_valid && !dstore && !walk_req_valid && exc_status == 0,
            "R1", "outputs after reset",
            {done, exc_valid, dstore, walk_req_valid}, 0);
    endtask

    task automatic t_miss_fill();
        w_found = 1; w_ppn = 20'h11111; w_pp = 2'b10;
        access(32'h1234_5678, 0, 0, 0, 0, 0, 24'hABCDE, 0, 0, 0);
        chk(res_walks == 1, "R1", "first data access walks", res_walks, 1);
        chk(res_vpn == {24'hABCDE, 16'h2345}, "R5", "walk vpn", res_vpn, {24'hABCDE, 16'h2345});
        chk(res_kind == 1 && res_pa == 32'h1111_1678, "R6", "refill then done pa", res_pa, 32'h1111_1678);
        access(32'h1234_5ABC, 0, 1, 0, 0, 0, 24'hABCDE, 0, 0, 0);
        chk(res_walks == 0 && res_kind == 1, "R6", "second access hits", res_walks, 0);
        chk(res_cycles == 2, "R11", "hit latency", res_cycles, 2);
        chk(res_pa == 32'h1111_1ABC, "R6", "hit pa", res_pa, 32'h1111_1ABC);
    endtask

    task automatic t_split_and_fault();
        w_found = 0; w_ppn = 0; w_pp = 0;
        access(32'h1234_5000, 1, 0, 0, 0, 0, 24'hABCDE, 0, 0, 0);
        chk(res_walks == 1, "R9", "fetch misses in instruction TLB", res_walks, 1);
        chk(res_kind == 2 && res_stat == 32'h4000_0000 && !res_data, "R7",
            "fetch page fault ISI bit 1", {res_data, res_stat}, 33'h0_4000_0000);
        access(32'h0999_9000, 0, 0, 0, 0, 0, 24'h00042, 0, 0, 0);
        chk(res_kind == 2 && res_stat == 32'h4000_0000 && res_data, "R7",
            "data page fault DSI bit 1", {res_data, res_stat}, 33'h1_4000_0000);
    endtask

    task automatic t_protect();
        w_found = 1; w_ppn = 20'h22222; w_pp = 2'b01;
        access(32'h0001_0000, 0, 1, 0, 0, 1, 24'h00100, 0, 0, 0);
        chk(res_kind == 2 && res_stat == 32'h0800_0000 && res_data, "R8",
            "key1 pp01 store denied", {res_data, res_stat}, 33'h1_0800_0000);
        access(32'h0001_0004, 0, 0, 0, 0, 1, 24'h00100, 0, 0, 0);
        chk(res_kind == 1 && res_pa == 32'h2222_2004, "R8", "key1 pp01 load allowed", res_pa, 32'h2222_2004);
        w_ppn = 20'h33333; w_pp = 2'b11;
        access(32'h0002_0000, 0, 1, 0, 0, 0, 24'h00100, 0, 0, 0);
        chk(res_kind == 2 && res_stat == 32'h0800_0000, "R8", "key0 pp11 store denied", res_stat, 32'h0800_0000);
        w_ppn = 20'h44444; w_pp = 2'b00;
        access(32'h0003_0000, 1, 0, 0, 0, 1, 24'h00100, 0, 0, 0);
        chk(res_kind == 2 && res_stat == 32'h0800_0000 && !res_data, "R8",
            "key1 pp00 fetch denied ISI", {res_data, res_stat}, 33'h0_0800_0000);
        access(32'h0003_0000, 1, 0, 0, 0, 0, 24'h00100, 0, 0, 0);
        chk(res_kind == 1 && res_walks == 0 && res_pa == 32'h4444_4000, "R8",
            "key0 pp00 fetch allowed", res_pa, 32'h4444_4000);
    endtask

    task automatic t_noexec();
        access(32'h0005_0000, 1, 0, 0, 1, 0, 24'h00200, 0, 0, 0);
        chk(res_kind == 2 && res_stat == 32'h1000_0000 && !res_data && res_walks == 0,
            "R3", "no-execute fetch ISI bit 3", {res_walks[0], res_data, res_stat}, 34'h0_1000_0000);
        chk(res_cycles == 2, "R11", "no-execute latency", res_cycles, 2);
        access(32'h1234_5010, 0, 0, 0, 1, 0, 24'hABCDE, 0, 0, 0);
        chk(res_kind == 1 && res_pa == 32'h1111_1010, "R3", "data ignores nx", res_pa, 32'h1111_1010);
    endtask

    task automatic t_block();
        access(32'hDEAD_BEEF, 0, 1, 0, 0, 0, 24'h00300, 1, 0, 20'h5A5A5);
        chk(res_kind == 1 && res_pa == 32'h5A5A_5EEF && res_walks == 0 && res_cycles == 2,
            "R2", "block match completes", res_pa, 32'h5A5A_5EEF);
        access(32'h0006_0000, 1, 0, 0, 1, 0, 24'h00300, 1, 1, 20'h00001);
        chk(res_kind == 2 && res_stat == 32'h0800_0000 && !res_data && res_walks == 0,
            "R2", "block violation bit 4", res_stat, 32'h0800_0000);
    endtask

    task automatic t_direct();
        access(32'h0007_0000, 0, 0, 1, 0, 0, 24'h00400, 0, 0, 0);
        chk(res_kind == 3 && res_walks == 0 && res_cycles == 2, "R4",
            "direct-store hand-off", res_kind, 3);
        chk(!dstore && !done && !exc_valid, "R11", "hand-off is one cycle", dstore, 0);
    endtask

    task automatic t_round_robin();
        do_reset();
        w_found = 1; w_pp = 2'b10;
        for (int p = 0; p < 5; p++) begin
            w_ppn = 20'h70000 + 20'(p);
            access({4'h0, 16'(p + 1), 12'h000}, 0, 0, 0, 0, 0, 24'h00500, 0, 0, 0);
        end
        access({4'h0, 16'd5, 12'h008}, 0, 0, 0, 0, 0, 24'h00500, 0, 0, 0);
        chk(res_walks == 0 && res_pa == 32'h7000_4008, "R10", "fifth page hits", res_walks, 0);
        w_ppn = 20'h70000;
        access({4'h0, 16'd1, 12'h008}, 0, 0, 0, 0, 0, 24'h00500, 0, 0, 0);
        chk(res_walks == 1, "R10", "first page evicted", res_walks, 1);
    endtask

    initial begin
        w_found = 0; w_ppn = 0; w_pp = 0;
        t_reset();
        t_miss_fill();
        t_split_and_fault();
        t_protect();
        t_noexec();
        t_block();
        t_direct();
        t_round_robin();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule